// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits between an 8-bit processor bus with a 16-bit address and a large cartridge ROM, plus an optional external RAM that is split into banks. Reads from the lower 16 KiB of the address space always see the first ROM bank. Reads from the upper 16 KiB of the ROM space see whichever bank the bank register selects. Reads from an 8 KiB window at 0xA000 see the selected RAM bank. Writes aimed at the ROM space never reach the ROM. Instead they load the control registers: the RAM enable, the ROM bank number and the RAM bank number.

The controller drives the physical ROM address and the RAM address, write data and write strobe. Both memories are read asynchronously. The byte returned to the processor is registered on the clock edge that samples the read strobe.

Build-time parameters set the number of ROM banks, the number of RAM banks, and whether RAM and a clock-register block are fitted. The clock registers are not built. When a clock is fitted, their select codes only park the RAM window.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the ROM bank register is 1, the RAM bank is 0, RAM access is disabled and the read data output holds 0xFF.
- R2: A read in 0x0000–0x3FFF returns ROM byte (address & 0x3FFF) of bank 0, whatever the bank register holds.
- R3: A read in 0x4000–0x7FFF returns the ROM byte at physical address bank × 0x4000 + (address & 0x3FFF). The bank field occupies rom_addr bits 14 and up.
- R4: A write in 0x2000–0x3FFF whose value exceeds ROM_BANKS−1 loads ROM_BANKS−1 into the bank register. Any value from 1 to ROM_BANKS−1 is loaded unchanged.
- R5: A write of 0x00 in 0x2000–0x3FFF loads bank 1.
- R6: In 0x0000–0x1FFF, writing 0x0A enables RAM access and writing 0x00 disables it. Any other value leaves the enable state unchanged.
- R7: In 0x4000–0x5FFF, the values 0x00–0x03 select the RAM bank. Values 0x04–0x07 and 0x0D–0xFF are ignored.
- R8: When the clock option is built, the values 0x08–0x0C written in 0x4000–0x5FFF park the RAM window on the absent clock registers. While parked, window reads return 0xFF and window writes are dropped, until a RAM bank code (0x00–0x03) is written. Without the clock option these values are ignored.
- R9: A read in 0xA000–0xBFFF returns the RAM byte at offset (address − 0xA000) + 0x2000 × RAM bank. It returns 0xFF instead when RAM is not fitted, is disabled, is parked, or when the bank is at or beyond RAM_BANKS.
- R10: A write in 0xA000–0xBFFF reaches the RAM only under the conditions where a read of the same address would return RAM data. Otherwise the write is dropped and no RAM byte changes.
- R11: Writes in 0x6000–0x7FFF change nothing. Reads in 0x8000–0x9FFF and 0xC000–0xFFFF return 0xFF.
- R12: The read data output changes only on a clock edge where the read strobe is high. At that edge it takes the byte addressed in the same cycle, and it holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| cpu_rdata | output | 8 | Registered read data |
| rom_addr | output | ROM_AW | Physical ROM byte address |
| rom_data | input | 8 | Asynchronous ROM read data |
| ram_addr | output | RAM_AW | RAM byte address (bank, offset) |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write strobe |
| ram_rdata | input | 8 | Asynchronous RAM read data |

## Verification
The bench builds the block with 64 ROM banks, 2 RAM banks, RAM fitted and the clock option on. With 64 ROM banks, a bank write of 0x50 has to clamp to 63. With only two RAM banks, bank codes 2 and 3 are legal selects that fall beyond the RAM, which exercises the 0xFF return and the dropped write. The clock option makes the parking codes reachable, so the bench can show a window that stays dark until a bank code is written again.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;

    typedef enum logic [2:0] {
        RGN_RAM_GATE = 3'd0,  // 0x0000-0x1FFF : ROM bank 0 / RAM enable writes
        RGN_ROM_SEL  = 3'd1,  // 0x2000-0x3FFF : ROM bank 0 / ROM bank writes
        RGN_RAM_SEL  = 3'd2,  // 0x4000-0x5FFF : switched ROM / RAM bank writes
        RGN_SPARE    = 3'd3,  // 0x6000-0x7FFF : switched ROM / writes ignored
        RGN_RAM_WIN  = 3'd4,  // 0xA000-0xBFFF : external RAM window
        RGN_NONE     = 3'd5   // everything else
    } region_e;

    localparam logic [7:0] RAM_ON_CODE  = 8'h0A;
    localparam logic [7:0] RAM_OFF_CODE = 8'h00;
    localparam logic [7:0] RAM_BANK_MAX = 8'h03;
    localparam logic [7:0] CLK_SEL_LO   = 8'h08;
    localparam logic [7:0] CLK_SEL_HI   = 8'h0C;
    localparam logic [7:0] OPEN_BUS     = 8'hFF;

    function automatic region_e decode_region(input logic [2:0] top_bits);
        case (top_bits)
            3'd0:    return RGN_RAM_GATE;
            3'd1:    return RGN_ROM_SEL;
            3'd2:    return RGN_RAM_SEL;
            3'd3:    return RGN_SPARE;
            3'd5:    return RGN_RAM_WIN;
            default: return RGN_NONE;
        endcase
    endfunction

endpackage

// File: rtl/cart_addr_decode.sv
module cart_addr_decode
    import cart_bank_pkg::*;
(
    input  logic [2:0] addr_top,
    output region_e    region,
    output logic       hit_rom_fixed,
    output logic       hit_rom_switched
);
    always_comb begin
        region           = decode_region(addr_top);
        hit_rom_fixed    = (region == RGN_RAM_GATE) || (region == RGN_ROM_SEL);
        hit_rom_switched = (region == RGN_RAM_SEL)  || (region == RGN_SPARE);
    end
endmodule

// File: rtl/cart_bank_regs.sv
module cart_bank_regs
    import cart_bank_pkg::*;
#(
    parameter int ROM_BANKS = 64,
    parameter bit HAS_CLOCK = 1'b0,
    localparam int ROM_BW   = $clog2(ROM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  region_e           region,
    input  logic [7:0]        wdata,
    output logic [ROM_BW-1:0] rom_bank,
    output logic [1:0]        ram_bank,
    output logic              ram_en,
    output logic              clk_park
);
    localparam logic [7:0]        TOP_BANK_8 = 8'(ROM_BANKS - 1);
    localparam logic [ROM_BW-1:0] TOP_BANK   = ROM_BW'(ROM_BANKS - 1);
    localparam logic [ROM_BW-1:0] FIRST_SW   = ROM_BW'(1);

    typedef struct packed {
        logic [ROM_BW-1:0] rom_bank;
        logic [1:0]        ram_bank;
        logic              ram_en;
        logic              clk_park;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            case (region)
                RGN_RAM_GATE: begin
                    if (wdata == RAM_ON_CODE)       st_d.ram_en = 1'b1;
                    else if (wdata == RAM_OFF_CODE) st_d.ram_en = 1'b0;
                end
                RGN_ROM_SEL: begin
                    if (wdata > TOP_BANK_8)  st_d.rom_bank = TOP_BANK;
                    else if (wdata == 8'h00) st_d.rom_bank = FIRST_SW;
                    else                     st_d.rom_bank = wdata[ROM_BW-1:0];
                end
                RGN_RAM_SEL: begin
                    if (wdata <= RAM_BANK_MAX) begin
                        st_d.ram_bank = wdata[1:0];
                        st_d.clk_park = 1'b0;
                    end else if (HAS_CLOCK && wdata >= CLK_SEL_LO && wdata <= CLK_SEL_HI) begin
                        st_d.clk_park = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.rom_bank <= FIRST_SW;
            st_q.ram_bank <= 2'd0;
            st_q.ram_en   <= 1'b0;
            st_q.clk_park <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rom_bank = st_q.rom_bank;
    assign ram_bank = st_q.ram_bank;
    assign ram_en   = st_q.ram_en;
    assign clk_park = st_q.clk_park;
endmodule

// File: rtl/cart_read_path.sv
module cart_read_path
    import cart_bank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd,
    input  region_e    region,
    input  logic       ram_open,
    input  logic [7:0] rom_data,
    input  logic [7:0] ram_rdata,
    output logic [7:0] rdata
);
    logic [7:0] rdata_d, rdata_q;
    logic [7:0] sel_byte;

    always_comb begin
        case (region)
            RGN_RAM_GATE, RGN_ROM_SEL,
            RGN_RAM_SEL,  RGN_SPARE:   sel_byte = rom_data;
            RGN_RAM_WIN:               sel_byte = ram_open ? ram_rdata : OPEN_BUS;
            default:                   sel_byte = OPEN_BUS;
        endcase
        rdata_d = rd ? sel_byte : rdata_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= OPEN_BUS;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
    import cart_bank_pkg::*;
#(
    parameter int ROM_BANKS = 64,
    parameter int RAM_BANKS = 4,
    parameter bit HAS_RAM   = 1'b1,
    parameter bit HAS_CLOCK = 1'b0,
    localparam int ROM_BW   = $clog2(ROM_BANKS),
    localparam int ROM_AW   = ROM_BW + 14,
    localparam int RAM_BW   = (RAM_BANKS > 1) ? $clog2(RAM_BANKS) : 1,
    localparam int RAM_AW   = RAM_BW + 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    output logic [7:0]        cpu_rdata,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic [7:0]        rom_data,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    output logic              ram_we,
    input  logic [7:0]        ram_rdata
);
    region_e           region;
    logic              hit_rom_fixed;
    logic              hit_rom_switched;
    logic [ROM_BW-1:0] rom_bank;
    logic [1:0]        ram_bank;
    logic              ram_en;
    logic              clk_park;
    logic              ram_open;

    cart_addr_decode u_dec (
        .addr_top         (cpu_addr[15:13]),
        .region           (region),
        .hit_rom_fixed    (hit_rom_fixed),
        .hit_rom_switched (hit_rom_switched)
    );

    cart_bank_regs #(
        .ROM_BANKS (ROM_BANKS),
        .HAS_CLOCK (HAS_CLOCK)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (cpu_wr),
        .region   (region),
        .wdata    (cpu_wdata),
        .rom_bank (rom_bank),
        .ram_bank (ram_bank),
        .ram_en   (ram_en),
        .clk_park (clk_park)
    );

    always_comb begin
        ram_open = HAS_RAM && ram_en && !clk_park && (int'(ram_bank) < RAM_BANKS);
        if (hit_rom_switched)   rom_addr = {rom_bank, cpu_addr[13:0]};
        else if (hit_rom_fixed) rom_addr = {ROM_BW'(0), cpu_addr[13:0]};
        else                    rom_addr = {ROM_BW'(0), cpu_addr[13:0]};
        ram_addr  = {ram_bank[RAM_BW-1:0], cpu_addr[12:0]};
        ram_wdata = cpu_wdata;
        ram_we    = cpu_wr && (region == RGN_RAM_WIN) && ram_open;
    end

    cart_read_path u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd        (cpu_rd),
        .region    (region),
        .ram_open  (ram_open),
        .rom_data  (rom_data),
        .ram_rdata (ram_rdata),
        .rdata     (cpu_rdata)
    );
endmodule

// File: rtl/cart_bank_chk.sv
module cart_bank_chk #(
    parameter int ROM_BANKS = 64,
    parameter int ROM_AW    = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       cpu_addr,
    input logic [7:0]        cpu_wdata,
    input logic              cpu_rd,
    input logic              cpu_wr,
    input logic [7:0]        cpu_rdata,
    input logic [ROM_AW-1:0] rom_addr,
    input logic              ram_we,
    input logic              ram_en
);
    // R2
    rom_fixed_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rd && cpu_addr[15:14] == 2'b00 |-> rom_addr[ROM_AW-1:14] == '0);

    // R4
    rom_bank_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rd && cpu_addr[15:14] == 2'b01 |->
            rom_addr[ROM_AW-1:14] != '0 && int'(rom_addr[ROM_AW-1:14]) <= ROM_BANKS - 1);

    // R10
    ram_we_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> cpu_wr && cpu_addr[15:13] == 3'b101 && ram_en);

    // R6
    ram_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr && cpu_addr[15:13] == 3'b000 && cpu_wdata == 8'h00 |=> !ram_en);

    // R11
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rd && (cpu_addr[15:13] == 3'b100 || cpu_addr[15:14] == 2'b11)
            |=> cpu_rdata == 8'hFF);

    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rd |=> $stable(cpu_rdata));
endmodule

bind cart_bank_ctrl cart_bank_chk #(
    .ROM_BANKS (ROM_BANKS),
    .ROM_AW    (ROM_AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .cpu_rdata (cpu_rdata),
    .rom_addr  (rom_addr),
    .ram_we    (ram_we),
    .ram_en    (ram_en)
);

// File: tb/cart_bank_ctrl_test.sv
`timescale 1ns/1ps
module cart_bank_ctrl_test;
    localparam int ROM_BANKS = 64;
    localparam int RAM_BANKS = 2;
    localparam int ROM_AW    = 20;
    localparam int RAM_AW    = 14;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       cpu_addr = '0;
    logic [7:0]        cpu_wdata = '0;
    logic              cpu_rd = 1'b0;
    logic              cpu_wr = 1'b0;
    logic [7:0]        cpu_rdata;
    logic [ROM_AW-1:0] rom_addr;
    logic [7:0]        rom_data;
    logic [RAM_AW-1:0] ram_addr;
    logic [7:0]        ram_wdata;
    logic              ram_we;
    logic [7:0]        ram_rdata;
    logic [7:0]        ram_mem [0:(1<<RAM_AW)-1];

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    cart_bank_ctrl #(
        .ROM_BANKS (ROM_BANKS),
        .RAM_BANKS (RAM_BANKS),
        .HAS_RAM   (1'b1),
        .HAS_CLOCK (1'b1)
    ) uut (
        .clk (clk), .rst_n (rst_n), .cpu_addr (cpu_addr), .cpu_wdata (cpu_wdata),
        .cpu_rd (cpu_rd), .cpu_wr (cpu_wr), .cpu_rdata (cpu_rdata),
        .rom_addr (rom_addr), .rom_data (rom_data), .ram_addr (ram_addr),
        .ram_wdata (ram_wdata), .ram_we (ram_we), .ram_rdata (ram_rdata)
    );

    // ROM model: byte = bank number XOR low offset byte
    assign rom_data  = 8'(rom_addr >> 14) ^ rom_addr[7:0];
    assign ram_rdata = ram_mem[ram_addr];
    always @(posedge clk) if (ram_we) ram_mem[ram_addr] <= ram_wdata;

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0;
        d = cpu_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 rdata after reset", cpu_rdata, 8'hFF);
        bus_read(16'h4000, d); check("R1 rom bank 1", d, 8'h01);
        bus_read(16'hA000, d); check("R1 ram disabled", d, 8'hFF);
    endtask

    task automatic t_rom_select();
        logic [7:0] d;
        bus_write(16'h2000, 8'h05);
        bus_read(16'h4000, d); check("R3 bank 5 base", d, 8'h05);
        bus_read(16'h7FFF, d); check("R3 bank 5 top", d, 8'hFA);
        bus_read(16'h0123, d); check("R2 fixed bank low", d, 8'h23);
        bus_read(16'h3F10, d); check("R2 fixed bank high", d, 8'h10);
    endtask

    task automatic t_clamp();
        logic [7:0] d;
        bus_write(16'h3FFF, 8'h50);
        bus_read(16'h4000, d); check("R4 clamp 0x50", d, 8'h3F);
        bus_write(16'h2000, 8'h3F);
        bus_read(16'h4000, d); check("R4 top bank kept", d, 8'h3F);
        bus_write(16'h2000, 8'h00);
        bus_read(16'h4000, d); check("R5 zero to one", d, 8'h01);
    endtask

    task automatic t_ram_gate();
        logic [7:0] d;
        bus_write(16'h0000, 8'h0A);
        bus_write(16'hA010, 8'h5A);
        bus_read(16'hA010, d); check("R9 ram readback", d, 8'h5A);
        bus_write(16'h1FFF, 8'h07);
        bus_read(16'hA010, d); check("R6 other value keeps enable", d, 8'h5A);
        bus_write(16'h0100, 8'h00);
        bus_read(16'hA010, d); check("R6 disable", d, 8'hFF);
        bus_write(16'hA010, 8'h77);
        bus_write(16'h0000, 8'h0A);
        bus_read(16'hA010, d); check("R10 disabled write dropped", d, 8'h5A);
    endtask

    task automatic t_ram_bank();
        logic [7:0] d;
        bus_write(16'h4000, 8'h01);
        bus_write(16'hA010, 8'h33);
        bus_read(16'hA010, d); check("R9 bank1 data", d, 8'h33);
        bus_write(16'h5FFF, 8'h00);
        bus_read(16'hA010, d); check("R7 bank0 data", d, 8'h5A);
        bus_write(16'h4000, 8'h02);
        bus_read(16'hA010, d); check("R9 bank beyond ram", d, 8'hFF);
        bus_write(16'hA010, 8'h99);
        bus_write(16'h4000, 8'h00);
        bus_read(16'hA010, d); check("R10 out of range write dropped", d, 8'h5A);
        bus_write(16'h4000, 8'h01);
        bus_write(16'h4000, 8'h05);
        bus_read(16'hA010, d); check("R7 code 0x05 ignored", d, 8'h33);
    endtask

    task automatic t_clock_park();
        logic [7:0] d;
        bus_write(16'h4000, 8'h08);
        bus_read(16'hA010, d); check("R8 parked read", d, 8'hFF);
        bus_write(16'hA010, 8'hC3);
        bus_write(16'h4000, 8'h0D);
        bus_read(16'hA010, d); check("R8 still parked after 0x0D", d, 8'hFF);
        bus_write(16'h4000, 8'h01);
        bus_read(16'hA010, d); check("R8 unparked, write dropped", d, 8'h33);
    endtask

    task automatic t_misc();
        logic [7:0] d;
        bus_write(16'h2000, 8'h09);
        bus_write(16'h6000, 8'h01);
        bus_write(16'h7FFF, 8'h00);
        bus_read(16'h4000, d); check("R11 spare write rom", d, 8'h09);
        bus_read(16'hA010, d); check("R11 spare write ram", d, 8'h33);
        bus_read(16'h8000, d); check("R11 unmapped 0x8000", d, 8'hFF);
        bus_read(16'h4000, d);
        bus_read(16'hC000, d); check("R11 unmapped 0xC000", d, 8'hFF);
        bus_read(16'hFFFF, d); check("R11 unmapped 0xFFFF", d, 8'hFF);
    endtask

    task automatic t_latency();
        logic [7:0] d;
        bus_read(16'h4001, d); check("R12 captured", d, 8'h08);
        cpu_addr = 16'h0044;
        repeat (3) @(negedge clk);
        check("R12 held without strobe", cpu_rdata, 8'h08);
    endtask

    initial begin
        for (int i = 0; i < (1 << RAM_AW); i++) ram_mem[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rom_select();
        t_clamp();
        t_ram_gate();
        t_ram_bank();
        t_clock_park();
        t_misc();
        t_latency();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule